// File: doc/BRIEF.md
# PCI Target Posted-Write Buffer

This block sits behind the target state machine of a PCI bus interface and absorbs posted memory writes. When the bus interface reports the address phase of a new transaction, the block checks the command and the window-hit result (window decode is done elsewhere and arrives as an input). If the write is accepted, the block keeps the start address and window number in a working register. Each data phase then pushes a 32-bit word and its byte enables into a data queue. When the transaction ends, one entry goes into a four-deep address queue. That entry holds the start address, the window number and the count of words that belong to the transaction.

Towards the bus, the block returns two per-cycle requests. `bus_retry` refuses a new write because one of the queues has no room. `bus_disc` accepts the current data phase and ends the burst there. A burst is ended early in three cases: the data queue fills, the burst reaches the last word of a 64-byte line, or the write targets the register window. Towards the inside of the chip, a drain port shows the oldest complete transaction with one data word at a time, together with that word's byte address. The consumer steps through the words with `drn_pop`.

Top module: `pci_wpost_buf`

## Requirements
- R1: A new transaction is taken only when `bus_cmd` is 4'b0111 (memory write) or 4'b1111 (memory write and invalidate) and `win_hit` is high. Any other start creates no entry, stores no data and raises no retry.
- R2: The address queue holds at most 4 entries. Each entry holds the start address, the window number and the word count, and entries are presented in the order their transactions ended.
- R3: Data words and their byte enables are kept in a 16-entry data queue and drained in arrival order. Word k of an entry is shown with `drn_waddr` = start address + 4*k.
- R4: In the cycle an accepted transaction starts, `bus_retry` is high if the address queue holds 4 entries or the data queue holds 16 words. Nothing from that transaction is stored.
- R5: A data phase after which the data queue holds 16 words is accepted with `bus_disc` high, and the transaction closes with that word.
- R6: A data phase whose byte address has bits [5:2] equal to 4'b1111 (the last word of a 64-byte line) is accepted with `bus_disc` high.
- R7: A write to window number 0 (the register window) is accepted for its first data phase only, with `bus_disc` high, so its entry has a count of 1.
- R8: `bus_retry` and `bus_disc` are never high in the same cycle.
- R9: `drn_avail` rises only on the clock edge that closes a transaction, never while its words are still arriving. An entry leaves the address queue when its last word (`drn_last` high) is popped.
- R10: After reset, `drn_avail`, `bus_retry` and `bus_disc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Address phase of a new transaction |
| bus_cmd | input | 4 | Bus command code of that transaction |
| bus_addr | input | AW | Start byte address |
| win_hit | input | 1 | Address falls in one of the target windows |
| win_id | input | IDW | Number of the window that was hit |
| bus_dvld | input | 1 | A data phase completes this cycle |
| bus_data | input | DW | Write data of the phase |
| bus_be | input | DW/8 | Byte enables of the phase |
| bus_last | input | 1 | Master marks this phase as its final one |
| bus_retry | output | 1 | Refuse the starting transaction |
| bus_disc | output | 1 | Accept this phase and end the burst |
| drn_avail | output | 1 | A complete transaction is at the drain head |
| drn_addr | output | AW | Start address of the head entry |
| drn_id | output | IDW | Window number of the head entry |
| drn_cnt | output | clog2(DQ_DEPTH+1) | Word count of the head entry |
| drn_data | output | DW | Current data word |
| drn_be | output | DW/8 | Byte enables of the current word |
| drn_waddr | output | AW | Byte address of the current word |
| drn_last | output | 1 | Current word is the last of the entry |
| drn_pop | input | 1 | Consume the current word |

## Verification
The checks assume a well-behaved bus side. `bus_start` arrives only when no transaction is open. Data phases begin in the cycle after an accepted start and stop at the phase that carries `bus_last` or draws `bus_disc`. `drn_pop` is raised only while `drn_avail` is high. The bench drives every transaction through one task that stops issuing phases as soon as `bus_disc` is seen, and it sends no data phases after a refused or ignored start. The drain task pops only while the drain port reports a valid head, so the bench never breaks these assumptions.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_OPEN = 1'b1
  } wr_state_e;

  function automatic logic is_post_cmd(input logic [3:0] cmd);
    return (cmd == CMD_MEM_WR) || (cmd == CMD_MEM_WRI);
  endfunction

endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));

endmodule

// File: rtl/pwb_wr_ctl.sv
module pwb_wr_ctl
  import pwb_pkg::*;
#(
  parameter int AW         = 32,
  parameter int IDW        = 2,
  parameter int DQ_DEPTH   = 16,
  parameter int LINE_BYTES = 64,
  parameter int REG_WIN    = 0,
  localparam int CNTW      = $clog2(DQ_DEPTH + 1),
  localparam int LB        = $clog2(LINE_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_start,
  input  logic [3:0]      bus_cmd,
  input  logic [AW-1:0]   bus_addr,
  input  logic            win_hit,
  input  logic [IDW-1:0]  win_id,
  input  logic            bus_dvld,
  input  logic            bus_last,
  input  logic            aq_full,
  input  logic            dq_full,
  input  logic [CNTW-1:0] dq_count,
  input  logic            dq_pop,
  output logic            bus_retry,
  output logic            bus_disc,
  output logic            dq_push,
  output logic            aq_push,
  output logic [AW-1:0]   ent_addr,
  output logic [IDW-1:0]  ent_id,
  output logic [CNTW-1:0] ent_cnt,
  output logic            ev_open,
  output logic            ev_disc_full,
  output logic            ev_disc_line,
  output logic            ev_disc_reg
);

  wr_state_e       state;
  logic [AW-1:0]   cur_addr;
  logic [IDW-1:0]  cur_id;
  logic [CNTW-1:0] wcnt;

  logic            start_ok;
  logic            phase;
  logic            close;
  logic [CNTW:0]   dq_next;
  logic [AW-1:0]   ph_addr;

  function automatic logic [AW-1:0] phase_addr(input logic [AW-1:0] base,
                                               input logic [CNTW-1:0] idx);
    return base + (AW'(idx) << 2);
  endfunction

  function automatic logic at_line_end(input logic [AW-1:0] a);
    return &a[LB-1:2];
  endfunction

  assign start_ok  = bus_start && (state == WS_IDLE) && is_post_cmd(bus_cmd) && win_hit;
  assign bus_retry = start_ok && (aq_full || dq_full);

  assign phase   = (state == WS_OPEN) && bus_dvld;
  assign dq_push = phase;
  assign ph_addr = phase_addr(cur_addr, wcnt);
  assign dq_next = {1'b0, dq_count} + (CNTW+1)'(1) - (CNTW+1)'(dq_pop);

  assign ev_disc_full = phase && (dq_next == (CNTW+1)'(DQ_DEPTH));
  assign ev_disc_line = phase && at_line_end(ph_addr);
  assign ev_disc_reg  = phase && (cur_id == IDW'(REG_WIN));
  assign bus_disc     = ev_disc_full || ev_disc_line || ev_disc_reg;

  assign close    = phase && (bus_last || bus_disc);
  assign aq_push  = close;
  assign ent_addr = cur_addr;
  assign ent_id   = cur_id;
  assign ent_cnt  = wcnt + 1'b1;
  assign ev_open  = (state == WS_OPEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= WS_IDLE;
      cur_addr <= '0;
      cur_id   <= '0;
      wcnt     <= '0;
    end else begin
      case (state)
        WS_IDLE: begin
          if (start_ok && !bus_retry) begin
            state    <= WS_OPEN;
            cur_addr <= bus_addr;
            cur_id   <= win_id;
            wcnt     <= '0;
          end
        end
        WS_OPEN: begin
          if (close) begin
            state <= WS_IDLE;
            wcnt  <= '0;
          end else if (phase) begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwb_drain.sv
module pwb_drain #(
  parameter int AW       = 32,
  parameter int IDW      = 2,
  parameter int DW       = 32,
  parameter int DQ_DEPTH = 16,
  localparam int BEW     = DW / 8,
  localparam int CNTW    = $clog2(DQ_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            aq_nonempty,
  input  logic [AW-1:0]   head_addr,
  input  logic [IDW-1:0]  head_id,
  input  logic [CNTW-1:0] head_cnt,
  input  logic [DW-1:0]   head_data,
  input  logic [BEW-1:0]  head_be,
  input  logic            drn_pop,
  output logic            drn_avail,
  output logic [AW-1:0]   drn_addr,
  output logic [IDW-1:0]  drn_id,
  output logic [CNTW-1:0] drn_cnt,
  output logic [DW-1:0]   drn_data,
  output logic [BEW-1:0]  drn_be,
  output logic [AW-1:0]   drn_waddr,
  output logic            drn_last,
  output logic            dq_pop,
  output logic            aq_pop
);

  logic [CNTW-1:0] consumed;
  logic            take;

  function automatic logic is_final(input logic [CNTW-1:0] done,
                                    input logic [CNTW-1:0] total);
    return (done + 1'b1) == total;
  endfunction

  function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] base,
                                              input logic [CNTW-1:0] idx);
    return base + (AW'(idx) << 2);
  endfunction

  assign drn_avail = aq_nonempty;
  assign drn_addr  = head_addr;
  assign drn_id    = head_id;
  assign drn_cnt   = head_cnt;
  assign drn_data  = head_data;
  assign drn_be    = head_be;
  assign drn_waddr = word_addr(head_addr, consumed);
  assign drn_last  = is_final(consumed, head_cnt);

  assign take   = drn_pop && aq_nonempty;
  assign dq_pop = take;
  assign aq_pop = take && drn_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      consumed <= '0;
    end else if (aq_pop) begin
      consumed <= '0;
    end else if (take) begin
      consumed <= consumed + 1'b1;
    end
  end

endmodule

// File: rtl/pci_wpost_buf.sv
module pci_wpost_buf #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int IDW        = 2,
  parameter int AQ_DEPTH   = 4,
  parameter int DQ_DEPTH   = 16,
  parameter int LINE_BYTES = 64,
  parameter int REG_WIN    = 0,
  localparam int BEW       = DW / 8,
  localparam int CNTW      = $clog2(DQ_DEPTH + 1),
  localparam int AQCW      = $clog2(AQ_DEPTH + 1),
  localparam int AQW       = AW + IDW + CNTW,
  localparam int DQW       = DW + BEW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_start,
  input  logic [3:0]      bus_cmd,
  input  logic [AW-1:0]   bus_addr,
  input  logic            win_hit,
  input  logic [IDW-1:0]  win_id,
  input  logic            bus_dvld,
  input  logic [DW-1:0]   bus_data,
  input  logic [BEW-1:0]  bus_be,
  input  logic            bus_last,
  output logic            bus_retry,
  output logic            bus_disc,
  output logic            drn_avail,
  output logic [AW-1:0]   drn_addr,
  output logic [IDW-1:0]  drn_id,
  output logic [CNTW-1:0] drn_cnt,
  output logic [DW-1:0]   drn_data,
  output logic [BEW-1:0]  drn_be,
  output logic [AW-1:0]   drn_waddr,
  output logic            drn_last,
  input  logic            drn_pop
);

  logic            aq_push, aq_pop, aq_full;
  logic [AQCW-1:0] aq_count;
  logic [AQW-1:0]  aq_wdata, aq_rdata;
  logic            dq_push, dq_pop, dq_full;
  logic [CNTW-1:0] dq_count;
  logic [DQW-1:0]  dq_rdata;
  logic [AW-1:0]   ent_addr;
  logic [IDW-1:0]  ent_id;
  logic [CNTW-1:0] ent_cnt;
  logic            ev_open, ev_disc_full, ev_disc_line, ev_disc_reg;

  pwb_wr_ctl #(
    .AW(AW), .IDW(IDW), .DQ_DEPTH(DQ_DEPTH),
    .LINE_BYTES(LINE_BYTES), .REG_WIN(REG_WIN)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .bus_start(bus_start), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .win_hit(win_hit), .win_id(win_id),
    .bus_dvld(bus_dvld), .bus_last(bus_last),
    .aq_full(aq_full), .dq_full(dq_full), .dq_count(dq_count), .dq_pop(dq_pop),
    .bus_retry(bus_retry), .bus_disc(bus_disc),
    .dq_push(dq_push), .aq_push(aq_push),
    .ent_addr(ent_addr), .ent_id(ent_id), .ent_cnt(ent_cnt),
    .ev_open(ev_open), .ev_disc_full(ev_disc_full),
    .ev_disc_line(ev_disc_line), .ev_disc_reg(ev_disc_reg)
  );

  assign aq_wdata = {ent_addr, ent_id, ent_cnt};

  pwb_fifo #(.W(AQW), .DEPTH(AQ_DEPTH)) u_aq (
    .clk(clk), .rst_n(rst_n),
    .push(aq_push), .wdata(aq_wdata), .pop(aq_pop),
    .rdata(aq_rdata), .count(aq_count), .full(aq_full)
  );

  pwb_fifo #(.W(DQW), .DEPTH(DQ_DEPTH)) u_dq (
    .clk(clk), .rst_n(rst_n),
    .push(dq_push), .wdata({bus_data, bus_be}), .pop(dq_pop),
    .rdata(dq_rdata), .count(dq_count), .full(dq_full)
  );

  pwb_drain #(.AW(AW), .IDW(IDW), .DW(DW), .DQ_DEPTH(DQ_DEPTH)) u_drn (
    .clk(clk), .rst_n(rst_n),
    .aq_nonempty(aq_count != '0),
    .head_addr(aq_rdata[AQW-1 -: AW]),
    .head_id(aq_rdata[CNTW +: IDW]),
    .head_cnt(aq_rdata[CNTW-1:0]),
    .head_data(dq_rdata[DQW-1 -: DW]),
    .head_be(dq_rdata[BEW-1:0]),
    .drn_pop(drn_pop),
    .drn_avail(drn_avail), .drn_addr(drn_addr), .drn_id(drn_id),
    .drn_cnt(drn_cnt), .drn_data(drn_data), .drn_be(drn_be),
    .drn_waddr(drn_waddr), .drn_last(drn_last),
    .dq_pop(dq_pop), .aq_pop(aq_pop)
  );

endmodule

// File: rtl/pci_wpost_buf_chk.sv
module pci_wpost_buf_chk #(
  parameter int AQ_DEPTH = 4,
  parameter int DQ_DEPTH = 16,
  parameter int IDW      = 2,
  parameter int AW       = 32,
  parameter int REG_WIN  = 0,
  localparam int CNTW    = $clog2(DQ_DEPTH + 1),
  localparam int AQCW    = $clog2(AQ_DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_retry,
  input logic            bus_disc,
  input logic            drn_avail,
  input logic            drn_pop,
  input logic [AW-1:0]   drn_addr,
  input logic [IDW-1:0]  drn_id,
  input logic [CNTW-1:0] drn_cnt,
  input logic [AQCW-1:0] aq_count,
  input logic [CNTW-1:0] dq_count,
  input logic            dq_push,
  input logic            dq_pop,
  input logic            ev_open
);

  AST_RETRY_DISC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_retry && bus_disc)); // R8

  AST_RETRY_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_retry |-> (aq_count == AQCW'(AQ_DEPTH)) || (dq_count == CNTW'(DQ_DEPTH))); // R4

  AST_RETRY_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_retry && !ev_open |=> !ev_open); // R4

  AST_DQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dq_push |-> (dq_count < CNTW'(DQ_DEPTH)) || dq_pop); // R5

  AST_FULL_DISCONNECTS: assert property (@(posedge clk) disable iff (!rst_n)
    dq_push && !bus_disc |=> dq_count < CNTW'(DQ_DEPTH)); // R5

  AST_AQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    aq_count <= AQCW'(AQ_DEPTH)); // R2

  AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    drn_avail && !drn_pop |=> drn_avail && $stable(drn_addr) && $stable(drn_cnt)); // R2

  AST_HEAD_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    drn_avail |-> (dq_count != '0) && (drn_cnt != '0)); // R9

  AST_REG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    drn_avail && (drn_id == IDW'(REG_WIN)) |-> drn_cnt == CNTW'(1)); // R7

endmodule

bind pci_wpost_buf pci_wpost_buf_chk #(
  .AQ_DEPTH(AQ_DEPTH), .DQ_DEPTH(DQ_DEPTH), .IDW(IDW), .AW(AW), .REG_WIN(REG_WIN)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_retry(bus_retry), .bus_disc(bus_disc),
  .drn_avail(drn_avail), .drn_pop(drn_pop),
  .drn_addr(drn_addr), .drn_id(drn_id), .drn_cnt(drn_cnt),
  .aq_count(aq_count), .dq_count(dq_count),
  .dq_push(dq_push), .dq_pop(dq_pop), .ev_open(ev_open)
);

// File: tb/tb_pci_wpost_buf.sv
module tb_pci_wpost_buf;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  // vector: [49:46] cmd, [45] hit, [44:43] id, [42:11] addr, [10:6] offered, [5] retry, [4:0] taken
  localparam logic [49:0] VEC [NV] = '{
    {4'h7, 1'b1, 2'd1, 32'h0000_1000, 5'd3,  1'b0, 5'd3},   // R3 plain burst
    {4'h6, 1'b1, 2'd1, 32'h0000_2000, 5'd2,  1'b0, 5'd0},   // R1 read command ignored
    {4'hF, 1'b0, 2'd1, 32'h0000_2100, 5'd2,  1'b0, 5'd0},   // R1 window miss ignored
    {4'hF, 1'b1, 2'd2, 32'h0000_3038, 5'd4,  1'b0, 5'd2},   // R6 line end
    {4'h7, 1'b1, 2'd0, 32'h0000_0010, 5'd3,  1'b0, 5'd1},   // R7 register window
    {4'h7, 1'b1, 2'd3, 32'h0000_4000, 5'd12, 1'b0, 5'd10},  // R5 data queue fills
    {4'h7, 1'b1, 2'd1, 32'h0000_5000, 5'd1,  1'b1, 5'd0},   // R4 both queues full
    {4'h7, 1'b0, 2'd1, 32'h0000_5100, 5'd1,  1'b0, 5'd0}    // R1 miss while full
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_start = 1'b0;
  logic [3:0]  bus_cmd = 4'h0;
  logic [31:0] bus_addr = '0;
  logic        win_hit = 1'b0;
  logic [1:0]  win_id = '0;
  logic        bus_dvld = 1'b0;
  logic [31:0] bus_data = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_last = 1'b0;
  logic        bus_retry, bus_disc;
  logic        drn_avail;
  logic [31:0] drn_addr;
  logic [1:0]  drn_id;
  logic [4:0]  drn_cnt;
  logic [31:0] drn_data;
  logic [3:0]  drn_be;
  logic [31:0] drn_waddr;
  logic        drn_last;
  logic        drn_pop = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int serial = 0;

  logic [31:0] sb_waddr [64];
  logic [31:0] sb_data  [64];
  logic [3:0]  sb_be    [64];
  int          sb_w = 0, sb_r = 0;
  logic [31:0] e_addr [32];
  logic [1:0]  e_id   [32];
  int          e_cnt  [32];
  int          e_w = 0, e_r = 0, e_pos = 0;

  pci_wpost_buf dut (
    .clk(clk), .rst_n(rst_n),
    .bus_start(bus_start), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .win_hit(win_hit), .win_id(win_id),
    .bus_dvld(bus_dvld), .bus_data(bus_data), .bus_be(bus_be), .bus_last(bus_last),
    .bus_retry(bus_retry), .bus_disc(bus_disc),
    .drn_avail(drn_avail), .drn_addr(drn_addr), .drn_id(drn_id), .drn_cnt(drn_cnt),
    .drn_data(drn_data), .drn_be(drn_be), .drn_waddr(drn_waddr), .drn_last(drn_last),
    .drn_pop(drn_pop)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic excl_chk();
    chk(!(bus_retry && bus_disc), "R8", "retry with disconnect",
        {62'd0, bus_retry, bus_disc}, 64'd0);
  endtask

  task automatic run_txn(input logic [3:0] cmd, input logic hit, input logic [1:0] id,
                         input logic [31:0] addr, input int offer,
                         output bit got_retry, output int taken, output bit disc_end);
    bit acc;
    got_retry = 1'b0;
    taken     = 0;
    disc_end  = 1'b0;
    acc = ((cmd == 4'h7) || (cmd == 4'hF)) && hit;
    bus_start = 1'b1; bus_cmd = cmd; bus_addr = addr; win_hit = hit; win_id = id;
    #1;
    got_retry = bus_retry;
    excl_chk();
    @(negedge clk);
    bus_start = 1'b0; win_hit = 1'b0;
    if (acc && !got_retry) begin
      for (int k = 0; k < offer; k++) begin
        bit d;
        serial++;
        bus_dvld = 1'b1;
        bus_data = 32'hD000_0000 | serial;
        bus_be   = 4'(serial) ^ 4'hA;
        bus_last = (k == offer - 1);
        #1;
        d = bus_disc;
        excl_chk();
        sb_waddr[sb_w] = addr + 32'(4 * k);
        sb_data[sb_w]  = bus_data;
        sb_be[sb_w]    = bus_be;
        sb_w++;
        taken++;
        @(negedge clk);
        if (d || (k == offer - 1)) begin
          disc_end = d;
          break;
        end
      end
      bus_dvld = 1'b0; bus_last = 1'b0;
      if (taken > 0) begin
        e_addr[e_w] = addr; e_id[e_w] = id; e_cnt[e_w] = taken; e_w++;
      end
    end
  endtask

  task automatic drain_words(input int n);
    for (int i = 0; i < n; i++) begin
      chk(drn_avail == 1'b1, "R9", "drain head present", 64'(drn_avail), 64'd1);
      if (e_pos == 0) begin
        chk(drn_addr == e_addr[e_r], "R2", "entry start address", 64'(drn_addr), 64'(e_addr[e_r]));
        chk(drn_id == e_id[e_r], "R2", "entry window", 64'(drn_id), 64'(e_id[e_r]));
        chk(int'(drn_cnt) == e_cnt[e_r], "R2", "entry word count", 64'(drn_cnt), 64'(e_cnt[e_r]));
      end
      chk(drn_data == sb_data[sb_r], "R3", "drained word", 64'(drn_data), 64'(sb_data[sb_r]));
      chk(drn_be == sb_be[sb_r], "R3", "drained enables", 64'(drn_be), 64'(sb_be[sb_r]));
      chk(drn_waddr == sb_waddr[sb_r], "R3", "word address", 64'(drn_waddr), 64'(sb_waddr[sb_r]));
      chk(drn_last == (e_pos == e_cnt[e_r] - 1), "R9", "last marker",
          64'(drn_last), 64'(e_pos == e_cnt[e_r] - 1));
      drn_pop = 1'b1;
      sb_r++;
      e_pos++;
      if (e_pos == e_cnt[e_r]) begin
        e_pos = 0;
        e_r++;
      end
      @(negedge clk);
    end
    drn_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit r, de;
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(drn_avail == 1'b0, "R10", "avail after reset", 64'(drn_avail), 64'd0);
    chk(bus_retry == 1'b0, "R10", "retry after reset", 64'(bus_retry), 64'd0);
    chk(bus_disc == 1'b0, "R10", "disc after reset", 64'(bus_disc), 64'd0);

    // table walk, drain held off
    for (int v = 0; v < NV; v++) begin
      logic [49:0] e;
      e = VEC[v];
      run_txn(e[49:46], e[45], e[44:43], e[42:11], int'(e[10:6]), r, t, de);
      chk(r == e[5], "R4", "retry response", 64'(r), 64'(e[5]));
      chk(t == int'(e[4:0]), "R5", "phases taken", 64'(t), 64'(e[4:0]));
      chk(de == (t < int'(e[10:6]) && t > 0), "R6", "early disconnect",
          64'(de), 64'(t < int'(e[10:6]) && t > 0));
    end
    // R1 R2 R3 R5 R6 R7: contents in order
    drain_words(16);
    chk(drn_avail == 1'b0, "R9", "empty after drain", 64'(drn_avail), 64'd0);

    // R9: entry appears only when the transaction closes
    bus_start = 1'b1; bus_cmd = 4'h7; bus_addr = 32'h7000; win_hit = 1'b1; win_id = 2'd1;
    @(negedge clk);
    bus_start = 1'b0; win_hit = 1'b0;
    bus_dvld = 1'b1; bus_data = 32'hCAFE_0001; bus_be = 4'hF; bus_last = 1'b0;
    sb_waddr[sb_w] = 32'h7000; sb_data[sb_w] = 32'hCAFE_0001; sb_be[sb_w] = 4'hF; sb_w++;
    @(negedge clk);
    chk(drn_avail == 1'b0, "R9", "avail during open burst", 64'(drn_avail), 64'd0);
    bus_data = 32'hCAFE_0002; bus_be = 4'h3; bus_last = 1'b1;
    sb_waddr[sb_w] = 32'h7004; sb_data[sb_w] = 32'hCAFE_0002; sb_be[sb_w] = 4'h3; sb_w++;
    @(negedge clk);
    bus_dvld = 1'b0; bus_last = 1'b0;
    e_addr[e_w] = 32'h7000; e_id[e_w] = 2'd1; e_cnt[e_w] = 2; e_w++;
    chk(drn_avail == 1'b1, "R9", "avail after close", 64'(drn_avail), 64'd1);
    drain_words(2);

    // R4: address queue full alone
    for (int i = 0; i < 4; i++) begin
      run_txn(4'h7, 1'b1, 2'd2, 32'h8000 + 32'(i * 64), 1, r, t, de);
      chk(r == 1'b0 && t == 1, "R2", "single-word write taken", 64'(t), 64'd1);
    end
    run_txn(4'hF, 1'b1, 2'd2, 32'h8400, 1, r, t, de);
    chk(r == 1'b1, "R4", "retry on full address queue", 64'(r), 64'd1);
    drain_words(1);
    run_txn(4'hF, 1'b1, 2'd2, 32'h8400, 1, r, t, de);
    chk(r == 1'b0 && t == 1, "R4", "accepted after slot freed", 64'(r), 64'd0);
    drain_words(4);

    // R6: line end on a single final phase still disconnects
    run_txn(4'h7, 1'b1, 2'd3, 32'h903C, 1, r, t, de);
    chk(de == 1'b1, "R6", "disconnect at line end", 64'(de), 64'd1);
    drain_words(1);
    chk(drn_avail == 1'b0, "R9", "empty at end", 64'(drn_avail), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule